// File: doc/BRIEF.md
# Serial Flash Command Execution Core

This block is the command core of a serial NOR flash slave. A shift front end decodes each chip-select frame. When chip select is released it pulses `frame_end_i` for one clock and presents the frame's first byte, the number of bits clocked in the frame, the second byte and the level of the active-low write-protect pin. The core keeps the status byte and decides whether each write-type command may run. It starts a busy period for each accepted internal cycle and sends one-cycle request strobes to the array controller, which lies outside this block.

A write-type command is one of status write, page program, sector erase or bulk erase. It is carried out only if three conditions hold: the write-enable latch was set by an earlier frame, the frame ended on a byte boundary with the right length, and no internal cycle is running. The status-lock bit together with a low write-protect pin makes the status byte read-only in hardware. Busy lengths are parameters counted in clock cycles, so short runs still go through every cycle type.

Top module: `flash_cmd_core`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `status_o` reads 8'h00.
- R2: A frame with opcode 8'h06 and exactly 8 bits sets the write-enable latch (`status_o[1]`). A frame with opcode 8'h04 and exactly 8 bits clears it. Either opcode with any other bit count has no effect.
- R3: Status write (8'h01), page program (8'h02), sector erase (8'hD8) and bulk erase (8'hC7) are refused when the write-enable latch is 0.
- R4: A write-type command is refused unless its bit count is a multiple of 8 and matches its length rule: status write at least 16, page program at least 40, sector erase exactly 32, bulk erase exactly 8.
- R5: An accepted page program, sector erase or bulk erase raises `prog_go_o`, `sect_erase_go_o` or `bulk_erase_go_o` for exactly the one cycle after the frame end. No strobe rises at any other time, and at most one is high in any cycle.
- R6: `status_o[0]` (busy) is 1 for exactly the parameter number of cycles for the cycle type (`DUR_WSR`, `DUR_PGM`, `DUR_SER`, `DUR_BER`), starting in the cycle after acceptance.
- R7: While busy, every frame end has no effect on the status byte or the strobes.
- R8: The write-enable latch clears in the same cycle that busy falls. A refused command leaves the latch unchanged.
- R9: An accepted status write loads `status_o[7]` from data bit 7 and `status_o[4:2]` from data bits 4:2. `status_o[6:5]` always read 0.
- R10: A status write is refused while `status_o[7]` is 1 and `wp_n_i` is 0. It is accepted when `wp_n_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_end_i | input | 1 | One-cycle pulse when chip select is released |
| opcode_i | input | 8 | First byte of the frame |
| frame_bits_i | input | FBW | Number of bits clocked in the frame |
| wdata_i | input | 8 | Second byte of the frame (status write data) |
| wp_n_i | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte: 7 lock, 4:2 protect level, 1 write enable, 0 busy |
| prog_go_o | output | 1 | Page program request strobe |
| sect_erase_go_o | output | 1 | Sector erase request strobe |
| bulk_erase_go_o | output | 1 | Bulk erase request strobe |

## Verification
The assertions check these properties on every cycle:
- the reset value of the status byte;
- strobes are one-hot and appear only after a cycle with the latch set and busy clear;
- the status byte is frozen while busy;
- the write-enable latch falls together with busy;
- the constant-zero bits stay zero.

Only the bench's scenarios can show the following:
- the exact busy length of each cycle type;
- the length and alignment rules;
- the hardware lock through the write-protect pin;
- which data bits a status write loads.

The bench checks these against a model that advances one step per clock, driven by random frames mixed with directed corner cases.

// File: rtl/flash_core_pkg.sv
// Shared opcodes and cycle kinds for the flash command core.
// Assumes the front end supplies the first frame byte unmodified.
package flash_core_pkg;
    localparam logic [7:0] OP_WEN   = 8'h06;
    localparam logic [7:0] OP_WDIS  = 8'h04;
    localparam logic [7:0] OP_WSTAT = 8'h01;
    localparam logic [7:0] OP_PGM   = 8'h02;
    localparam logic [7:0] OP_SER   = 8'hD8;
    localparam logic [7:0] OP_BER   = 8'hC7;

    typedef enum logic [2:0] {
        CYC_NONE = 3'd0,
        CYC_WSR  = 3'd1,
        CYC_PGM  = 3'd2,
        CYC_SER  = 3'd3,
        CYC_BER  = 3'd4
    } cyc_kind_e;
endpackage

// File: rtl/fcc_decode.sv
// Command gate: turns a frame end into latch set/clear or a cycle start.
// Assumes frame_end is a single-cycle pulse; purely combinational.
module fcc_decode
    import flash_core_pkg::*;
#(
    parameter int FBW = 12
) (
    input  logic           frame_end,
    input  logic [7:0]     opcode,
    input  logic [FBW-1:0] frame_bits,
    input  logic           busy,
    input  logic           wel,
    input  logic           lock,
    input  logic           wp_n,
    output logic           wel_set,
    output logic           wel_clr,
    output cyc_kind_e      start
);
    localparam logic [FBW-1:0] LEN_1B = FBW'(8);
    localparam logic [FBW-1:0] LEN_2B = FBW'(16);
    localparam logic [FBW-1:0] LEN_4B = FBW'(32);
    localparam logic [FBW-1:0] LEN_5B = FBW'(40);

    logic aligned;
    logic armed;

    // Frame must close on a byte boundary to be eligible for write-type work.
    assign aligned = (frame_bits[2:0] == 3'b000);
    assign armed   = frame_end && !busy;

    // Decode the opcode against length, latch and lock rules.
    always_comb begin
        wel_set = 1'b0;
        wel_clr = 1'b0;
        start   = CYC_NONE;
        if (armed) begin
            case (opcode)
                OP_WEN:   if (frame_bits == LEN_1B) wel_set = 1'b1;
                OP_WDIS:  if (frame_bits == LEN_1B) wel_clr = 1'b1;
                OP_WSTAT: if (wel && aligned && frame_bits >= LEN_2B && !(lock && !wp_n))
                              start = CYC_WSR;
                OP_PGM:   if (wel && aligned && frame_bits >= LEN_5B) start = CYC_PGM;
                OP_SER:   if (wel && frame_bits == LEN_4B) start = CYC_SER;
                OP_BER:   if (wel && frame_bits == LEN_1B) start = CYC_BER;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/fcc_busy_timer.sv
// Busy timer: loads the duration of the started cycle kind and counts down.
// Assumes no start arrives while busy (gated by the decoder); durations >= 1.
module fcc_busy_timer
    import flash_core_pkg::*;
#(
    parameter int DUR_WSR = 20,
    parameter int DUR_PGM = 40,
    parameter int DUR_SER = 100,
    parameter int DUR_BER = 300
) (
    input  logic      clk,
    input  logic      rst_n,
    input  cyc_kind_e start,
    output logic      busy,
    output logic      done
);
    localparam int MAX_A = (DUR_WSR > DUR_PGM) ? DUR_WSR : DUR_PGM;
    localparam int MAX_B = (DUR_SER > DUR_BER) ? DUR_SER : DUR_BER;
    localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_D + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;

    // Select the countdown length for the cycle kind being started.
    always_comb begin
        case (start)
            CYC_WSR: load_val = CW'(DUR_WSR);
            CYC_PGM: load_val = CW'(DUR_PGM);
            CYC_SER: load_val = CW'(DUR_SER);
            CYC_BER: load_val = CW'(DUR_BER);
            default: load_val = '0;
        endcase
    end

    // Count remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (start != CYC_NONE) cnt <= load_val;
        else if (cnt != '0)        cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
endmodule

// File: rtl/fcc_status.sv
// Status holder: write-enable latch, protect level and lock bit.
// Assumes set/clear/load requests are mutually exclusive with done.
module fcc_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wel_set,
    input  logic       wel_clr,
    input  logic       wsr_load,
    input  logic [7:0] wdata,
    input  logic       done,
    output logic       wel,
    output logic       lock,
    output logic [2:0] prot
);
    logic unused_wbits;
    assign unused_wbits = ^{wdata[6:5], wdata[1:0]};

    // Write-enable latch: completion clears, commands set or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel <= 1'b0;
        else if (done)    wel <= 1'b0;
        else if (wel_set) wel <= 1'b1;
        else if (wel_clr) wel <= 1'b0;
    end

    // Protect level and lock bit load from an accepted status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= 1'b0;
            prot <= 3'b000;
        end else if (wsr_load) begin
            lock <= wdata[7];
            prot <= wdata[4:2];
        end
    end
endmodule

// File: rtl/flash_cmd_core.sv
// Top of the flash command core: gates write-type frames, keeps the status
// byte, runs the busy timer and strobes the array controller.
// Assumes frame fields are valid in the cycle frame_end_i is high.
module flash_cmd_core
    import flash_core_pkg::*;
#(
    parameter int FBW     = 12,
    parameter int DUR_WSR = 20,
    parameter int DUR_PGM = 40,
    parameter int DUR_SER = 100,
    parameter int DUR_BER = 300
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_end_i,
    input  logic [7:0]     opcode_i,
    input  logic [FBW-1:0] frame_bits_i,
    input  logic [7:0]     wdata_i,
    input  logic           wp_n_i,
    output logic [7:0]     status_o,
    output logic           prog_go_o,
    output logic           sect_erase_go_o,
    output logic           bulk_erase_go_o
);
    localparam int N_GO = 3;

    logic      busy, done, wel, lock, wel_set, wel_clr;
    logic [2:0] prot;
    cyc_kind_e start;
    logic [N_GO-1:0] go_q;

    fcc_decode #(.FBW(FBW)) u_decode (
        .frame_end (frame_end_i),
        .opcode    (opcode_i),
        .frame_bits(frame_bits_i),
        .busy      (busy),
        .wel       (wel),
        .lock      (lock),
        .wp_n      (wp_n_i),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr),
        .start     (start)
    );

    fcc_busy_timer #(
        .DUR_WSR(DUR_WSR), .DUR_PGM(DUR_PGM),
        .DUR_SER(DUR_SER), .DUR_BER(DUR_BER)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .busy (busy),
        .done (done)
    );

    fcc_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wel_set (wel_set),
        .wel_clr (wel_clr),
        .wsr_load(start == CYC_WSR),
        .wdata   (wdata_i),
        .done    (done),
        .wel     (wel),
        .lock    (lock),
        .prot    (prot)
    );

    // One registered request strobe per array cycle kind.
    for (genvar g = 0; g < N_GO; g++) begin : g_go
        localparam cyc_kind_e KIND = cyc_kind_e'(g + 2);
        always_ff @(posedge clk) begin
            if (!rst_n) go_q[g] <= 1'b0;
            else        go_q[g] <= (start == KIND);
        end
    end

    assign prog_go_o       = go_q[0];
    assign sect_erase_go_o = go_q[1];
    assign bulk_erase_go_o = go_q[2];
    assign status_o        = {lock, 2'b00, prot, wel, busy};
endmodule

// File: rtl/fcc_props.sv
// Checker for the flash command core; bound to the top module below.
// Assumes the core's port timing; observes ports only.
module fcc_props (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status_o,
    input logic [2:0] go
);
    // R1: reset leaves the status byte clear.
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> status_o == 8'h00);

    // R5: at most one request strobe at a time.
    p_go_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(go));

    // R3: a strobe needs the latch set and no cycle running one cycle earlier.
    p_go_needs_wel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go != 3'b000) |-> $past(status_o[1]) && !$past(status_o[0]));

    // R7: while busy, protect, lock and latch bits hold still.
    p_busy_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status_o[0]) && status_o[0] |-> $stable(status_o[7:1]));

    // R7: no strobe follows a busy cycle.
    p_busy_no_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status_o[0]) |-> go == 3'b000);

    // R8: latch clears as busy falls.
    p_wel_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o[0]) |-> !status_o[1]);

    // R9: reserved bits stay zero.
    p_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:5] == 2'b00);
endmodule

bind flash_cmd_core fcc_props u_props (
    .clk     (clk),
    .rst_n   (rst_n),
    .status_o(status_o),
    .go      ({bulk_erase_go_o, sect_erase_go_o, prog_go_o})
);

// File: tb/flash_cmd_core_tb.sv
// Self-checking bench: directed corner cases then seeded random frames,
// compared each cycle against a step model written from the requirements.
module flash_cmd_core_tb;
    localparam int FBW = 12;
    localparam int D_WSR = 5, D_PGM = 9, D_SER = 13, D_BER = 17;
    localparam int CLK_NS = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fe = 1'b0, wp_n = 1'b1;
    logic [7:0] op = 8'h00, wd = 8'h00;
    logic [FBW-1:0] bits = '0;
    logic [7:0] status;
    logic pgo, sgo, bgo;

    int n_chk = 0, n_fail = 0;

    // Reference model state (post-edge).
    logic m_wel = 0, m_lock = 0;
    logic [2:0] m_prot = 0, m_go = 0;
    int m_cnt = 0;

    always #(CLK_NS/2) clk = ~clk;

    flash_cmd_core #(.FBW(FBW), .DUR_WSR(D_WSR), .DUR_PGM(D_PGM),
                     .DUR_SER(D_SER), .DUR_BER(D_BER)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_end_i(fe), .opcode_i(op),
        .frame_bits_i(bits), .wdata_i(wd), .wp_n_i(wp_n), .status_o(status),
        .prog_go_o(pgo), .sect_erase_go_o(sgo), .bulk_erase_go_o(bgo)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {m_lock, 2'b00, m_prot, m_wel, (m_cnt != 0)};
    endfunction

    // Advance the model by one clock edge given the driven inputs.
    task automatic model_step();
        logic al;
        al = (bits[2:0] == 3'b000);
        m_go = 3'b000;
        if (!rst_n) begin
            m_wel = 0; m_lock = 0; m_prot = 0; m_cnt = 0;
        end else if (m_cnt != 0) begin
            m_cnt--;
            if (m_cnt == 0) m_wel = 0;
        end else if (fe) begin
            case (op)
                8'h06: if (bits == 8) m_wel = 1;
                8'h04: if (bits == 8) m_wel = 0;
                8'h01: if (m_wel && al && bits >= 16 && !(m_lock && !wp_n)) begin
                           m_cnt = D_WSR; m_lock = wd[7]; m_prot = wd[4:2];
                       end
                8'h02: if (m_wel && al && bits >= 40) begin m_cnt = D_PGM; m_go = 3'b001; end
                8'hD8: if (m_wel && bits == 32) begin m_cnt = D_SER; m_go = 3'b010; end
                8'hC7: if (m_wel && bits == 8) begin m_cnt = D_BER; m_go = 3'b100; end
                default: ;
            endcase
        end
    endtask

    // One cycle: compare outputs at the negedge, then drive and step model.
    task automatic tick(input logic f, input logic [7:0] o, input int b,
                        input logic [7:0] d, input logic w);
        logic [7:0] e;
        @(negedge clk);
        e = exp_status();
        check("R6 busy",   {7'b0, status[0]}, {7'b0, e[0]});
        check("R2 latch",  {7'b0, status[1]}, {7'b0, e[1]});
        check("R9 fields", {status[7:2], 2'b00}, {e[7:2], 2'b00});
        check("R5 strobe", {5'b0, bgo, sgo, pgo}, {5'b0, m_go});
        fe = f; op = o; bits = FBW'(b); wd = d; wp_n = w;
        model_step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 8'h00, 0, 8'h00, 1);
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        int nb;
        int seed;
        seed = 32'h1A2B3C4D;
        void'($urandom(seed));
        for (int i = 0; i < 3; i++) begin @(negedge clk); model_step(); end
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        check("R1 reset", status, 8'h00);

        tick(1, 8'h02, 40, 8'h00, 1); idle(1);           // R3: no latch
        check("R3 refused", {status[7:1], bgo | sgo | pgo}, 8'h00);
        tick(1, 8'h06, 12, 8'h00, 1); idle(1);           // R2: wrong length
        check("R2 len", status, 8'h00);
        tick(1, 8'h06, 8, 8'h00, 1); idle(1);
        check("R2 set", status, 8'h02);
        tick(1, 8'h02, 44, 8'h00, 1); idle(1);           // R4 unaligned, R8 keep
        check("R4 unaligned", status, 8'h02);
        tick(1, 8'hD8, 40, 8'h00, 1); idle(1);
        check("R8 kept", status, 8'h02);
        tick(1, 8'h02, 40, 8'h00, 1); idle(1);
        check("R5 prog", {status, 5'b0, bgo, sgo, pgo}[7:0], 8'h01);
        check("R6 start", status, 8'h03);
        nb = 0;
        for (int i = 0; i < D_PGM + 4; i++) begin
            if (status[0]) nb++;
            if (i == 2)      tick(1, 8'h04, 8, 8'h00, 1);   // R7
            else if (i == 3) tick(1, 8'hC7, 8, 8'h00, 1);   // R7
            else             tick(0, 8'h00, 0, 8'h00, 1);
            if (i == 4) check("R7 ignored", status, 8'h03);
        end
        check("R6 length", 8'(nb), 8'(D_PGM));
        check("R8 cleared", status, 8'h00);

        tick(1, 8'h06, 8, 8'h00, 1);
        tick(1, 8'h01, 16, 8'hFF, 1); idle(1);
        check("R9 load", status, 8'h9F);
        idle(D_WSR + 1);
        check("R9 done", status, 8'h9C);
        tick(1, 8'h06, 8, 8'h00, 1);
        tick(1, 8'h01, 16, 8'h00, 0); idle(1);
        check("R10 locked", status, 8'h9E);
        tick(1, 8'h01, 16, 8'h00, 1); idle(D_WSR + 2);
        check("R10 unlocked", status, 8'h00);
        tick(1, 8'h06, 8, 8'h00, 1);
        tick(1, 8'h04, 8, 8'h00, 1); idle(1);
        check("R2 clear", status, 8'h00);

        for (int i = 0; i < 4000; i++) begin
            logic [7:0] o;
            int b;
            case ($urandom % 8)
                0: o = 8'h06; 1: o = 8'h04; 2: o = 8'h01; 3: o = 8'h02;
                4: o = 8'hD8; 5: o = 8'hC7; 6: o = 8'h06; default: o = 8'($urandom);
            endcase
            case ($urandom % 7)
                0: b = 8; 1: b = 16; 2: b = 32; 3: b = 40;
                4: b = 48; 5: b = 12; default: b = int'($urandom % 80);
            endcase
            tick(($urandom % 3) == 0, o, b, 8'($urandom), ($urandom % 4) != 0);
        end
        idle(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule